// File: doc/BRIEF.md
# SPI Receive Queue with Overflow Control

This block buffers received SPI frames between the serial receiver and whatever drains them, whether a host or a DMA engine. When the receiver signals that a frame is complete, the frame enters a small first-in first-out queue of four entries. If the queue is full, the frame stays parked in a one-frame holding stage, which stands in for the receive shift register. The parked frame moves into the queue as soon as a pop frees a slot. A pop strobe takes the oldest entry. The head of the queue is always visible on the read-data port.

If a new transfer begins while both the queue and the holding stage are full, the block raises a sticky overflow flag. A mode input then decides what happens to the frame from that transfer. It either replaces the parked frame or is thrown away. A drain-request flag tells the reader that data is waiting. That flag clears either through a DMA completion strobe once the queue is empty, or through a software write-one-to-clear. A synchronous flush input empties the whole structure.

Top module: `spi_rx_queue`

## Requirements
- R1: After reset the level is 0 and both the overflow flag and the drain flag are 0.
- R2: While the queue has room, each frame_done pushes frame_data and raises the level by one. Frames leave in arrival order. The oldest unread entry is always shown on pop_data, and each pop advances to the next entry, wrapping after the fourth.
- R3: A frame completed while the queue is full is held in the holding stage. It enters the queue in the same cycle that a pop frees a slot, so the level stays at 4 in that cycle.
- R4: If xfer_start arrives while the queue is full and the holding stage is occupied, ovf_flag is set. It then stays set until it is cleared by a write.
- R5: With keep_ovf = 0, the frame that completes after an overflowing xfer_start is discarded, and the held frame is preserved.
- R6: With keep_ovf = 1, the frame that completes after an overflowing xfer_start replaces the held frame.
- R7: A pop while the level is 0 is ignored, and the level stays 0.
- R8: A push and a pop in the same cycle are both performed, and the level is unchanged.
- R9: drain_flag is 1 in every cycle after one in which the level ends nonzero. It clears only when the level is 0 and either dma_done is pulsed or a clear write with clr_bits[1] = 1 occurs. A nonempty level overrides any clear.
- R10: A clear write (clr_wr = 1) clears ovf_flag when clr_bits[0] = 1 and drain_flag when clr_bits[1] = 1. A 0 in either bit leaves that flag unchanged.
- R11: flush empties the queue and the holding stage, zeroes both pointers and the level, and clears drain_flag. ovf_flag is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous empty of queue and holding stage |
| keep_ovf | input | 1 | 1: overflowing frame replaces held frame; 0: it is dropped |
| frame_done | input | 1 | Receiver completed a frame this cycle |
| frame_data | input | W | Completed frame |
| xfer_start | input | 1 | A new serial transfer begins |
| pop | input | 1 | Read strobe of the queue head |
| pop_data | output | W | Oldest entry (stale when empty) |
| dma_done | input | 1 | DMA reports its pop read finished |
| clr_wr | input | 1 | Status clear write strobe |
| clr_bits | input | 2 | Write-one-to-clear mask: bit 0 overflow, bit 1 drain |
| level | output | $clog2(DEPTH)+1 | Number of queued entries |
| ovf_flag | output | 1 | Sticky receive overflow |
| drain_flag | output | 1 | Data waiting to be read |

## Verification
The checker watches several properties in every cycle. The level must never exceed the depth. The drain flag must follow a nonempty level. An overflow must raise the flag, and the flag must stay sticky until a clear write removes it. An empty pop, a simultaneous push and pop, and a flush must each produce the level the rules require. Data ordering and the handling of the held frame need the bench's scripted sequences to show them: the parked frame entering on a pop, a dropped frame never appearing, and an overwritten frame replacing the parked one. The same applies to drain clearing by DMA completion as opposed to software.

// File: rtl/spi_rx_queue.sv
module spi_rx_queue #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          keep_ovf,
  input  logic          frame_done,
  input  logic [W-1:0]  frame_data,
  input  logic          xfer_start,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  input  logic          dma_done,
  input  logic          clr_wr,
  input  logic [1:0]    clr_bits,
  output logic [CW-1:0] level,
  output logic          ovf_flag,
  output logic          drain_flag
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, cnt_nxt;
  logic [W-1:0]  hold_d;
  logic          hold_v, drop_pend, ovf_q, drn_q;

  wire full      = (cnt == CW'(DEPTH));
  wire empty     = (cnt == '0);
  wire do_pop    = pop && !empty;
  wire room      = !full || do_pop;
  wire take      = frame_done && !drop_pend;
  wire push_hold = hold_v && room;
  wire push_new  = take && !hold_v && room;
  wire do_push   = push_hold || push_new;
  wire [W-1:0] push_d = hold_v ? hold_d : frame_data;
  wire overrun   = xfer_start && full && hold_v;

  assign cnt_nxt = cnt + CW'(do_push) - CW'(do_pop);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      hold_v    <= 1'b0;
      hold_d    <= '0;
      drop_pend <= 1'b0;
      drn_q     <= 1'b0;
    end else if (flush) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      hold_v    <= 1'b0;
      drop_pend <= 1'b0;
      drn_q     <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt_nxt;

      if (take && (hold_v || !room)) begin
        hold_v <= 1'b1;
        hold_d <= frame_data;
      end else if (push_hold) begin
        hold_v <= 1'b0;
      end

      if (overrun && !keep_ovf) drop_pend <= 1'b1;
      else if (frame_done)      drop_pend <= 1'b0;

      if (cnt_nxt != '0)
        drn_q <= 1'b1;
      else if (dma_done || (clr_wr && clr_bits[1]))
        drn_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ovf_q <= 1'b0;
    else if (overrun)                  ovf_q <= 1'b1;
    else if (clr_wr && clr_bits[0])    ovf_q <= 1'b0;
  end

  assign pop_data   = mem[rd_ptr];
  assign level      = cnt;
  assign ovf_flag   = ovf_q;
  assign drain_flag = drn_q;

endmodule

// File: rtl/spi_rx_queue_chk.sv
module spi_rx_queue_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          frame_done,
  input logic          xfer_start,
  input logic          pop,
  input logic          clr_wr,
  input logic [1:0]    clr_bits,
  input logic [CW-1:0] level,
  input logic          ovf_flag,
  input logic          drain_flag,
  input logic          hold_v,
  input logic          drop_pend
);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  assert_drain_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> drain_flag);

  assert_overflow_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && level == CW'(DEPTH) && hold_v && !flush) |=> ovf_flag);

  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(clr_wr && clr_bits[0])) |=> ovf_flag);

  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && pop && !frame_done && !hold_v) |=> level == '0);

  assert_push_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !drop_pend && pop && level != '0 && level != CW'(DEPTH) && !flush)
      |=> $stable(level));

  assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && !drain_flag && !hold_v));

endmodule

bind spi_rx_queue spi_rx_queue_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .frame_done(frame_done),
  .xfer_start(xfer_start), .pop(pop), .clr_wr(clr_wr), .clr_bits(clr_bits),
  .level(level), .ovf_flag(ovf_flag), .drain_flag(drain_flag),
  .hold_v(hold_v), .drop_pend(drop_pend)
);

// File: tb/test_spi_rx_queue.sv
module test_spi_rx_queue;
  localparam int W = 16;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0;
  logic flush = 0, keep_ovf = 0, frame_done = 0, xfer_start = 0, pop = 0;
  logic dma_done = 0, clr_wr = 0;
  logic [1:0] clr_bits = 0;
  logic [W-1:0] frame_data = 0;
  logic [W-1:0] pop_data;
  logic [CW-1:0] level;
  logic ovf_flag, drain_flag;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  spi_rx_queue #(.W(W), .DEPTH(4)) i_spi_rx_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .keep_ovf(keep_ovf),
    .frame_done(frame_done), .frame_data(frame_data), .xfer_start(xfer_start),
    .pop(pop), .pop_data(pop_data), .dma_done(dma_done), .clr_wr(clr_wr),
    .clr_bits(clr_bits), .level(level), .ovf_flag(ovf_flag),
    .drain_flag(drain_flag)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        fl, fd, xs, pp, dd, cw;
    logic [1:0]  cb;
    logic        kp;
    logic [15:0] din;
    logic [2:0]  e_lvl;
    logic        e_ovf, e_drn, chk_d;
    logic [15:0] e_dat;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    // req fl fd xs pp dd cw cb kp din        lvl ovf drn chk dat
    '{4'd2, 0,1,0,0,0,0,2'd0,0,16'hA001, 3'd1,0,1,1,16'hA001}, // R2
    '{4'd2, 0,1,0,0,0,0,2'd0,0,16'hA002, 3'd2,0,1,1,16'hA001}, // R2
    '{4'd2, 0,1,0,0,0,0,2'd0,0,16'hA003, 3'd3,0,1,1,16'hA001}, // R2
    '{4'd2, 0,1,0,0,0,0,2'd0,0,16'hA004, 3'd4,0,1,1,16'hA001}, // R2
    '{4'd3, 0,1,0,0,0,0,2'd0,0,16'hA005, 3'd4,0,1,1,16'hA001}, // R3 parked
    '{4'd4, 0,0,1,0,0,0,2'd0,0,16'h0000, 3'd4,1,1,1,16'hA001}, // R4
    '{4'd5, 0,1,0,0,0,0,2'd0,0,16'hA006, 3'd4,1,1,1,16'hA001}, // R5 dropped
    '{4'd3, 0,0,0,1,0,0,2'd0,0,16'h0000, 3'd4,1,1,1,16'hA002}, // R3 parked moves in
    '{4'd2, 0,0,0,1,0,0,2'd0,0,16'h0000, 3'd3,1,1,1,16'hA003}, // R2
    '{4'd2, 0,0,0,1,0,0,2'd0,0,16'h0000, 3'd2,1,1,1,16'hA004}, // R2
    '{4'd5, 0,0,0,1,0,0,2'd0,0,16'h0000, 3'd1,1,1,1,16'hA005}, // R5 A006 absent
    '{4'd10,0,0,0,0,0,1,2'd0,0,16'h0000, 3'd1,1,1,1,16'hA005}, // R10 zero mask
    '{4'd10,0,0,0,0,0,1,2'd1,0,16'h0000, 3'd1,0,1,1,16'hA005}, // R10 clear ovf
    '{4'd8, 0,1,0,1,0,0,2'd0,0,16'hB001, 3'd1,0,1,1,16'hB001}, // R8
    '{4'd9, 0,0,0,1,0,0,2'd0,0,16'h0000, 3'd0,0,1,0,16'h0000}, // R9 stays set
    '{4'd7, 0,0,0,1,0,0,2'd0,0,16'h0000, 3'd0,0,1,0,16'h0000}, // R7
    '{4'd9, 0,0,0,0,1,0,2'd0,0,16'h0000, 3'd0,0,0,0,16'h0000}, // R9 dma clear
    '{4'd2, 0,1,0,0,0,0,2'd0,1,16'hC001, 3'd1,0,1,1,16'hC001}, // R2 wrap
    '{4'd9, 0,0,0,0,0,1,2'd2,1,16'h0000, 3'd1,0,1,1,16'hC001}, // R9 set wins
    '{4'd2, 0,1,0,0,0,0,2'd0,1,16'hC002, 3'd2,0,1,1,16'hC001}, // R2
    '{4'd2, 0,1,0,0,0,0,2'd0,1,16'hC003, 3'd3,0,1,1,16'hC001}, // R2
    '{4'd2, 0,1,0,0,0,0,2'd0,1,16'hC004, 3'd4,0,1,1,16'hC001}, // R2
    '{4'd3, 0,1,0,0,0,0,2'd0,1,16'hC005, 3'd4,0,1,1,16'hC001}, // R3
    '{4'd4, 0,0,1,0,0,0,2'd0,1,16'h0000, 3'd4,1,1,1,16'hC001}, // R4
    '{4'd6, 0,1,0,0,0,0,2'd0,1,16'hC006, 3'd4,1,1,1,16'hC001}, // R6 overwrite
    '{4'd3, 0,0,0,1,0,0,2'd0,1,16'h0000, 3'd4,1,1,1,16'hC002}, // R3
    '{4'd2, 0,0,0,1,0,0,2'd0,1,16'h0000, 3'd3,1,1,1,16'hC003}, // R2
    '{4'd2, 0,0,0,1,0,0,2'd0,1,16'h0000, 3'd2,1,1,1,16'hC004}, // R2
    '{4'd6, 0,0,0,1,0,0,2'd0,1,16'h0000, 3'd1,1,1,1,16'hC006}, // R6
    '{4'd9, 0,0,0,1,0,0,2'd0,1,16'h0000, 3'd0,1,1,0,16'h0000}, // R9
    '{4'd10,0,0,0,0,0,1,2'd2,1,16'h0000, 3'd0,1,0,0,16'h0000}, // R10 clear drain
    '{4'd2, 0,1,0,0,0,0,2'd0,0,16'hD001, 3'd1,1,1,1,16'hD001}, // R2
    '{4'd11,1,0,0,0,0,0,2'd0,0,16'h0000, 3'd0,1,0,0,16'h0000}, // R11
    '{4'd11,0,1,0,0,0,0,2'd0,0,16'hD002, 3'd1,1,1,1,16'hD002}, // R11 pointers zero
    '{4'd9, 0,0,0,1,1,0,2'd0,0,16'h0000, 3'd0,1,0,0,16'h0000}  // R9 pop+dma
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input int req, input logic [2:0] l, input logic o, input logic d);
    check(req, "level", 32'(level), 32'(l));
    check(req, "ovf_flag", 32'(ovf_flag), 32'(o));
    check(req, "drain_flag", 32'(drain_flag), 32'(d));
  endtask

  task automatic idle();
    flush = 0; frame_done = 0; xfer_start = 0; pop = 0;
    dma_done = 0; clr_wr = 0; clr_bits = 0;
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state(1, 3'd0, 1'b0, 1'b0); // R1
    rst_n = 1;
    @(negedge clk);
    check_state(1, 3'd0, 1'b0, 1'b0); // R1

    for (int i = 0; i < NV; i++) begin
      flush = VECS[i].fl; frame_done = VECS[i].fd; xfer_start = VECS[i].xs;
      pop = VECS[i].pp; dma_done = VECS[i].dd; clr_wr = VECS[i].cw;
      clr_bits = VECS[i].cb; keep_ovf = VECS[i].kp; frame_data = VECS[i].din;
      @(negedge clk);
      check_state(int'(VECS[i].req), VECS[i].e_lvl, VECS[i].e_ovf, VECS[i].e_drn);
      if (VECS[i].chk_d) check(int'(VECS[i].req), "pop_data", 32'(pop_data), 32'(VECS[i].e_dat));
    end
    idle();

    // R7 empty pop after flush leaves level zero and drain clear
    flush = 1; @(negedge clk); idle();
    pop = 1; @(negedge clk); idle();
    check_state(7, 3'd0, 1'b1, 1'b0); // R7

    // R1 reset in mid-run clears everything
    frame_done = 1; frame_data = 16'hE001; @(negedge clk); idle();
    rst_n = 0; @(negedge clk);
    check_state(1, 3'd0, 1'b0, 1'b0); // R1
    rst_n = 1; @(negedge clk);

    // R11 flush with a parked frame discards the parked frame too
    for (int k = 0; k < 5; k++) begin
      frame_done = 1; frame_data = 16'(16'hF000 + k); @(negedge clk);
    end
    idle();
    flush = 1; @(negedge clk); idle();
    pop = 1; @(negedge clk); idle();
    check_state(11, 3'd0, 1'b0, 1'b0); // R11

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule